// File: doc/BRIEF.md
# Self-Test Pattern Generator and Signature Compressor

This block is a small built-in self-test engine. On a start request it loads a nonzero 4-bit seed into a maximal-length linear feedback shift register (LFSR) and drives that register's state onto a pattern bus. The pattern bus feeds a combinational circuit under test. On every clock of the run, the circuit's 4-bit response is folded into a second shift register of the same form: a multi-input signature register.

After the programmed number of patterns the engine stops. For one cycle it raises `done_o`, together with a pass flag that compares the final signature against a golden constant. Because a given seed and count always give the same pattern stream, the golden value can be computed ahead of time from a fault-free model and compared with the hardware result.

A zero seed would lock the generator. The engine therefore refuses it: it loads the pattern register with the safe value 4'b1000, raises an error flag, and stays idle.

Top module: `bist_engine`

## Requirements
- R1: After reset, `pat_o` is 4'b1000, `sig_o` is 0, and `done_o`, `pass_o` and `seed_err_o` are low.
- R2: While running, the pattern register steps as next = {s[0]^s[1], s[3], s[2], s[1]}. Seeded with 4'b1000, it visits 15 distinct nonzero values and then repeats, a period of 15.
- R3: A start accepted in idle with a nonzero seed puts that seed on `pat_o` and clears `sig_o` to 0, both visible in the cycle after the start edge.
- R4: On each run cycle the signature steps as next = {s[0]^s[1]^r[3], s[3]^r[2], s[2]^r[1], s[1]^r[0]}, where r is `resp_i` in that cycle and the first pattern is the seed.
- R5: A start with a zero seed loads 4'b1000 into the pattern register, sets `seed_err_o`, and begins no run (`done_o` stays low). The next start with a nonzero seed clears `seed_err_o`.
- R6: `done_o` is high for exactly one cycle, in the cycle that follows `count_i`+1 rising edges counted from the start edge. A count of 0 gives `done_o` in the next cycle with signature 0.
- R7: `pass_o` is high only while `done_o` is high and `sig_o` equals the golden parameter `EXP_SIG`.
- R8: A start request while a run is in progress is ignored: the seed, count and result of the ongoing run are unchanged.
- R9: The same seed and count always reproduce the same signature, and a single stuck-at-0 fault on the example circuit's bit-0 output changes the signature and drops `pass_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled in idle only |
| seed_i | input | WIDTH | Initial generator value, must be nonzero |
| count_i | input | CNT_W | Number of patterns to apply |
| pat_o | output | WIDTH | Test pattern to the circuit under test |
| resp_i | input | WIDTH | Parallel response of the circuit under test |
| sig_o | output | WIDTH | Current signature |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Signature matches golden, valid with `done_o` |
| seed_err_o | output | 1 | Last start was refused for a zero seed |

## Verification
A wrong pattern-register state appears on `pat_o` in the very next cycle. It then changes every response that follows, so the final signature is also off. A corrupted signature bit shows on `sig_o` one cycle later and persists: the compressor is linear, so the error only cancels if a later error happens to alias with it. A wrong cycle counter moves the `done_o` pulse away from the `count_i`+1 edge point, and the bench checks that exact cycle.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bist_state_e;

    localparam int unsigned DEF_WIDTH = 4;
    localparam int unsigned DEF_CNT_W = 8;

endpackage

// File: rtl/bist_lfsr_gen.sv
module bist_lfsr_gen #(
    parameter int unsigned WIDTH    = 4,
    parameter logic [WIDTH-1:0] TAPS     = 4'b0011,
    parameter logic [WIDTH-1:0] RST_SEED = 4'b1000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] state_o
);

    typedef struct packed {
        logic [WIDTH-1:0] lfsr;
    } gen_regs_t;

    gen_regs_t r_d, r_q;
    logic      fb;

    always_comb begin
        r_d = r_q;
        fb  = ^(r_q.lfsr & TAPS);
        if (load_i) begin
            r_d.lfsr = load_val_i;
        end else if (step_i) begin
            r_d.lfsr = {fb, r_q.lfsr[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.lfsr <= RST_SEED;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.lfsr;

    assert_state_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.lfsr != '0);

    assert_no_load_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(load_i && step_i));

    assert_hold_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !step_i) |=> $stable(r_q.lfsr));

endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
    parameter int unsigned WIDTH = 4,
    parameter logic [WIDTH-1:0] TAPS = 4'b0011
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] resp_i,
    output logic [WIDTH-1:0] sig_o
);

    typedef struct packed {
        logic [WIDTH-1:0] sig;
    } misr_regs_t;

    misr_regs_t r_d, r_q;
    logic       fb;

    always_comb begin
        r_d = r_q;
        fb  = ^(r_q.sig & TAPS);
        if (clear_i) begin
            r_d.sig = '0;
        end else if (step_i) begin
            r_d.sig = {fb, r_q.sig[WIDTH-1:1]} ^ resp_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.sig <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign sig_o = r_q.sig;

    assert_clear_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(clear_i) |-> (r_q.sig == '0));

    assert_sig_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !step_i) |=> $stable(r_q.sig));

endmodule

// File: rtl/bist_ctrl.sv
module bist_ctrl
    import bist_pkg::*;
#(
    parameter int unsigned WIDTH    = 4,
    parameter int unsigned CNT_W    = 8,
    parameter logic [WIDTH-1:0] RST_SEED = 4'b1000,
    parameter logic [WIDTH-1:0] EXP_SIG  = 4'h0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [WIDTH-1:0] sig_i,
    output logic             load_o,
    output logic [WIDTH-1:0] load_val_o,
    output logic             step_o,
    output logic             clear_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             err_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        bist_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
        logic             err;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        load_o     = 1'b0;
        load_val_o = RST_SEED;
        step_o     = 1'b0;
        clear_o    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    load_o = 1'b1;
                    if (seed_i == '0) begin
                        load_val_o = RST_SEED;
                        r_d.err    = 1'b1;
                    end else begin
                        load_val_o = seed_i;
                        clear_o    = 1'b1;
                        r_d.err    = 1'b0;
                        r_d.cnt    = '0;
                        r_d.lim    = count_i;
                        r_d.state  = (count_i == '0) ? ST_DONE : ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                step_o  = 1'b1;
                r_d.cnt = r_q.cnt + CNT_ONE;
                if (r_q.cnt == r_q.lim - CNT_ONE) begin
                    r_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.lim   <= '0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = (r_q.state == ST_DONE);
    assign pass_o = done_o && (sig_i == EXP_SIG);
    assign err_o  = r_q.err;

    assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_pass_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_o |-> done_o);

    assert_err_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (r_q.state == ST_IDLE));

    assert_limit_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_RUN) |=> $stable(r_q.lim));

    assert_count_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_RUN) |-> (r_q.cnt < r_q.lim));

endmodule

// File: rtl/bist_engine.sv
module bist_engine
    import bist_pkg::*;
#(
    parameter int unsigned WIDTH    = DEF_WIDTH,
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter logic [WIDTH-1:0] TAPS     = 4'b0011,
    parameter logic [WIDTH-1:0] RST_SEED = 4'b1000,
    parameter logic [WIDTH-1:0] EXP_SIG  = 4'h0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [WIDTH-1:0] pat_o,
    input  logic [WIDTH-1:0] resp_i,
    output logic [WIDTH-1:0] sig_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             seed_err_o
);

    logic             load;
    logic [WIDTH-1:0] load_val;
    logic             step;
    logic             clear;

    bist_ctrl #(
        .WIDTH    (WIDTH),
        .CNT_W    (CNT_W),
        .RST_SEED (RST_SEED),
        .EXP_SIG  (EXP_SIG)
    ) ctrl_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .seed_i     (seed_i),
        .count_i    (count_i),
        .sig_i      (sig_o),
        .load_o     (load),
        .load_val_o (load_val),
        .step_o     (step),
        .clear_o    (clear),
        .done_o     (done_o),
        .pass_o     (pass_o),
        .err_o      (seed_err_o)
    );

    bist_lfsr_gen #(
        .WIDTH    (WIDTH),
        .TAPS     (TAPS),
        .RST_SEED (RST_SEED)
    ) gen_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .load_val_i (load_val),
        .step_i     (step),
        .state_o    (pat_o)
    );

    bist_misr #(
        .WIDTH (WIDTH),
        .TAPS  (TAPS)
    ) misr_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear),
        .step_i  (step),
        .resp_i  (resp_i),
        .sig_o   (sig_o)
    );

    assert_err_no_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(seed_err_o) |-> (pat_o == RST_SEED));

endmodule

// File: tb/bist_engine_tb_top.sv
`timescale 1ns/1ps
module bist_engine_tb_top;

    localparam int W = 4;
    localparam int CW = 8;

    function automatic logic [3:0] lfsr_nx(input logic [3:0] s);
        return {s[0] ^ s[1], s[3], s[2], s[1]};
    endfunction

    function automatic logic [3:0] misr_nx(input logic [3:0] s, input logic [3:0] r);
        return {s[0] ^ s[1] ^ r[3], s[3] ^ r[2], s[2] ^ r[1], s[1] ^ r[0]};
    endfunction

    // example circuit under test; fault 1 = output bit 0 stuck at 0
    function automatic logic [3:0] cut_fn(input logic [3:0] p, input logic [1:0] f);
        logic [3:0] y;
        y[0] = p[0] & p[1];
        y[1] = p[1] | p[2];
        y[2] = p[2] ^ p[3];
        y[3] = ~(p[0] & p[3]);
        if (f == 2'd1) y[0] = 1'b0;
        return y;
    endfunction

    function automatic logic [3:0] calc_sig(input logic [3:0] seed, input int cnt, input logic [1:0] f);
        logic [3:0] s;
        logic [3:0] g;
        s = seed;
        g = 4'h0;
        for (int i = 0; i < cnt; i++) begin
            g = misr_nx(g, cut_fn(s, f));
            s = lfsr_nx(s);
        end
        return g;
    endfunction

    localparam logic [3:0] GOLD = calc_sig(4'b1000, 15, 2'd0);

    // {seed, count}
    localparam logic [11:0] VEC [6] = '{
        {4'h8, 8'd15}, {4'h1, 8'd7}, {4'hF, 8'd1},
        {4'h6, 8'd30}, {4'h8, 8'd0}, {4'h8, 8'd15}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  seed = '0;
    logic [CW-1:0] count = '0;
    logic [W-1:0]  pat;
    logic [W-1:0]  resp;
    logic [W-1:0]  sig;
    logic          done;
    logic          pass;
    logic          serr;
    logic [1:0]    fault = 2'd0;
    int            n_chk = 0;
    int            n_err = 0;
    bit            finished = 1'b0;

    always #10 clk = ~clk;

    always_comb resp = cut_fn(pat, fault);

    bist_engine #(.WIDTH(W), .CNT_W(CW), .EXP_SIG(GOLD)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .seed_i     (seed),
        .count_i    (count),
        .pat_o      (pat),
        .resp_i     (resp),
        .sig_o      (sig),
        .done_o     (done),
        .pass_o     (pass),
        .seed_err_o (serr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // start a run at a negedge; poke > 0 pulses a foreign start at that run cycle
    task automatic run_case(input logic [3:0] sd, input int cnt, input int poke);
        logic [3:0] exp_sig;
        bit early;
        exp_sig = calc_sig(sd, cnt, fault);
        early = 1'b0;
        start = 1'b1; seed = sd; count = CW'(cnt);
        @(negedge clk);
        start = 1'b0;
        check(sig == 4'h0, "R3 signature cleared", int'(sig), 0);
        if (cnt > 0) check(pat == sd, "R3 seed loaded", int'(pat), int'(sd));
        for (int k = 1; k <= cnt; k++) begin
            if (k > 1) @(negedge clk);
            start = 1'b0;
            if (done) early = 1'b1;
            if (k == poke) begin
                start = 1'b1; seed = 4'h6; count = 8'd3;
            end
        end
        if (cnt > 0) @(negedge clk);
        start = 1'b0;
        check(!early, "R6 no early done", int'(early), 0);
        check(done == 1'b1, "R6 done at count+1", int'(done), 1);
        check(sig == exp_sig, "R4 R9 signature", int'(sig), int'(exp_sig));
        check(pass == (exp_sig == GOLD), "R7 pass flag", int'(pass), int'(exp_sig == GOLD));
        @(negedge clk);
        check(done == 1'b0, "R6 single-cycle done", int'(done), 0);
        check(pass == 1'b0, "R7 pass low without done", int'(pass), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [3:0] seen [16];
        logic [3:0] first_sig;
        bit distinct;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pat == 4'b1000, "R1 reset pattern", int'(pat), 8);
        check(sig == 4'h0, "R1 reset signature", int'(sig), 0);
        check(!done && !pass && !serr, "R1 reset flags", int'({done, pass, serr}), 0);

        // table walk
        for (int v = 0; v < 6; v++) begin
            run_case(VEC[v][11:8], int'(VEC[v][7:0]), 0);
            if (v == 0) first_sig = sig;
        end

        // R2 period of the generator
        start = 1'b1; seed = 4'b1000; count = 8'd20;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 16; i++) begin
            seen[i] = pat;
            @(negedge clk);
        end
        distinct = 1'b1;
        for (int i = 0; i < 15; i++) begin
            if (seen[i] == 4'h0) distinct = 1'b0;
            for (int j = 0; j < i; j++) if (seen[i] == seen[j]) distinct = 1'b0;
        end
        check(distinct, "R2 fifteen distinct nonzero", int'(distinct), 1);
        check(seen[15] == seen[0], "R2 period 15", int'(seen[15]), int'(seen[0]));
        check(seen[1] == lfsr_nx(4'b1000), "R2 step rule", int'(seen[1]), int'(lfsr_nx(4'b1000)));
        repeat (6) @(negedge clk);

        // R8 start during run is ignored
        run_case(4'b1000, 15, 4);
        check(pass == 1'b0 && sig == GOLD, "R8 result unchanged after poke", int'(sig), int'(GOLD));

        // R5 zero seed refused
        start = 1'b1; seed = 4'h0; count = 8'd4;
        @(negedge clk);
        start = 1'b0;
        check(serr == 1'b1, "R5 error flag", int'(serr), 1);
        check(pat == 4'b1000, "R5 forced pattern", int'(pat), 8);
        begin
            bit any_done;
            any_done = 1'b0;
            for (int i = 0; i < 6; i++) begin
                if (done) any_done = 1'b1;
                @(negedge clk);
            end
            check(!any_done, "R5 no run on zero seed", int'(any_done), 0);
            check(pat == 4'b1000, "R5 pattern held", int'(pat), 8);
        end
        start = 1'b1; seed = 4'h3; count = 8'd2;
        @(negedge clk);
        start = 1'b0;
        check(serr == 1'b0, "R5 error cleared", int'(serr), 0);
        repeat (4) @(negedge clk);

        // R9 stuck-at fault changes the signature
        fault = 2'd1;
        run_case(4'b1000, 15, 0);
        fault = 2'd0;
        check(calc_sig(4'b1000, 15, 2'd1) != GOLD, "R9 fault model differs", int'(calc_sig(4'b1000, 15, 2'd1)), int'(GOLD));
        run_case(4'b1000, 15, 0);
        check(sig == first_sig, "R9 repeatable signature", int'(sig), int'(first_sig));

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule